// File: doc/BRIEF.md
# Triggered Parallel Panel Write Sequencer

The block sends one frame of pixel words to a display panel that keeps its own frame memory. It uses an 8080-style parallel bus with an active-low chip select, an active-low write strobe, a register-select line and a data bus. Software programs four phase lengths for every write cycle through a small register port: chip-select setup, strobe setup, strobe active width and hold. It also sets the frame size in words. A single software trigger then starts a one-shot transfer. The block pulls pixels from a ready/valid stream and drives them word by word. At the end of the frame it raises an interrupt flag. It stays busy until software clears that flag.

No frame starts on its own. Only the software trigger begins a transfer. A trigger that arrives while a frame is still owned by the block is dropped, because restarting a panel mid-frame can corrupt it. The tearing-effect input from the panel is watched during the transfer. A tearing pulse that arrives before the frame is finished is recorded as a late-frame event. This lets software see that the write clock was sized too low (it should run at about twice the rate of htotal × vtotal × refresh).

Register map, word addressed on `reg_addr`:
- 0, timing: [19:16] chip-select setup, [15:12] strobe setup, [11:8] strobe active, [7:4] hold, [0] interface enable. Reset value 0x00000100.
- 1, trigger: [0] trigger mode, [1] start command (write-only, reads 0).
- 2, status: [0] frame done, [1] late tearing event. Both are write-1-to-clear.
- 3, size: [DIM_W-1:0] words per line, [16+DIM_W-1:16] lines.

Top module: `i80_frame_writer`

## Requirements
- R1: After reset, cs_n and wr_n are 1, busy, irq and pix_ready are 0, and register 0 reads 0x00000100.
- R2: A frame starts only on a write to register 1 with bits 1 and 0 both set while timing bit 0 is 1. Any other trigger write leaves busy at 0 and the bus idle.
- R3: In every word, cs_n is low for exactly (chip-select setup + strobe setup) cycles before wr_n falls.
- R4: wr_n stays low for exactly the active count, or 1 cycle when that count is 0. wr_n is only low while cs_n is low, and db holds the accepted pixel, unchanged, for the whole low time.
- R5: After wr_n rises, cs_n stays low for exactly the hold count, then goes high for at least one cycle before the next word.
- R6: A frame writes exactly (words per line × lines) words, in the order they were accepted. pix_ready is high only while busy.
- R7: When the last word completes, irq and status bit 0 rise. busy and irq then stay high until a 1 is written to status bit 0, and both are low one cycle after that write. A frame size of 0 raises irq with no bus cycle.
- R8: A trigger write while busy, including while waiting for the done flag to be cleared, adds no words and leaves busy high.
- R9: A rising edge on te, seen while words are still pending or on the bus, sets status bit 1. An edge while idle or in the done state does not. Writing 1 to status bit 1 clears it.
- R10: rs is 1 whenever cs_n is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display write clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_valid | input | 1 | Pixel word available |
| pix_ready | output | 1 | Block accepts a pixel word |
| pix_data | input | DATA_W | Pixel word |
| te | input | 1 | Tearing-effect pulse from the panel |
| cs_n | output | 1 | Panel chip select, active low |
| wr_n | output | 1 | Panel write strobe, active low |
| rs | output | 1 | Register select, 1 for pixel data |
| db | output | DATA_W | Panel data bus |
| busy | output | 1 | Frame owned by the block |
| irq | output | 1 | Frame-done interrupt |

## Verification
The tearing-edge detector and the end-of-frame transition can act in the same clock edge. A te edge can land exactly on the edge where the last strobe of the frame completes and the done flag is raised. The bench provokes this by raising te during the final strobe-low cycle of the last word, with the hold count at 0. It then expects both the done flag and the late-event flag to read back as set, since the word was still on the bus when the edge was sampled. A second case raises te in the done state and expects the late flag to stay clear. The single-cycle race between a repeated trigger and the frame's own progress is also provoked, both mid-frame and in the done state. It is judged by the word count and by busy.

// File: rtl/i80_frame_writer.sv
module i80_frame_writer #(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              pix_valid,
  output logic              pix_ready,
  input  logic [DATA_W-1:0] pix_data,
  input  logic              te,
  output logic              cs_n,
  output logic              wr_n,
  output logic              rs,
  output logic [DATA_W-1:0] db,
  output logic              busy,
  output logic              irq
);
  localparam int PH_W  = 4;
  localparam int CNT_W = 2 * DIM_W;
  localparam logic [1:0] A_TIME = 2'd0, A_TRIG = 2'd1, A_STAT = 2'd2, A_SIZE = 2'd3;

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_CSS, S_WRS, S_ACT, S_HOLD, S_DONE} state_t;

  state_t            state, nxt, first_ph, after_css, after_act, after_hold;
  logic [PH_W-1:0]   cs_set, wr_set, wr_act, wr_hold, act_eff, cnt;
  logic              en, mode, done_flag, te_late, te_q;
  logic [DIM_W-1:0]  hsize, vsize;
  logic [CNT_W-1:0]  left, total;
  logic [DATA_W-1:0] db_q;
  logic              unused_bits;

  wire wr_time  = reg_wr && reg_addr == A_TIME;
  wire wr_trig  = reg_wr && reg_addr == A_TRIG;
  wire wr_stat  = reg_wr && reg_addr == A_STAT;
  wire wr_size  = reg_wr && reg_addr == A_SIZE;
  wire trig_req = wr_trig && reg_wdata[1] && reg_wdata[0] && en;
  wire clr_done = wr_stat && reg_wdata[0];
  wire clr_late = wr_stat && reg_wdata[1];
  wire take     = state == S_FETCH && pix_valid;
  wire in_xfer  = state inside {S_FETCH, S_CSS, S_WRS, S_ACT, S_HOLD};
  wire te_rise  = te && !te_q;

  assign unused_bits = ^reg_wdata;
  assign act_eff = (wr_act == '0) ? PH_W'(1) : wr_act;
  assign total   = CNT_W'(hsize) * CNT_W'(vsize);

  always_comb begin
    after_hold = (left == '0) ? S_DONE : S_FETCH;
    after_act  = (wr_hold != '0) ? S_HOLD : after_hold;
    after_css  = (wr_set != '0) ? S_WRS : S_ACT;
    first_ph   = (cs_set != '0) ? S_CSS : after_css;
  end

  function automatic logic [PH_W-1:0] load_for(state_t s);
    case (s)
      S_CSS:   return cs_set - PH_W'(1);
      S_WRS:   return wr_set - PH_W'(1);
      S_ACT:   return act_eff - PH_W'(1);
      S_HOLD:  return wr_hold - PH_W'(1);
      default: return '0;
    endcase
  endfunction

  always_comb begin
    nxt = state;
    case (state)
      S_IDLE:  if (trig_req) nxt = (total == '0) ? S_DONE : S_FETCH;
      S_FETCH: if (pix_valid) nxt = first_ph;
      S_CSS:   if (cnt == '0) nxt = after_css;
      S_WRS:   if (cnt == '0) nxt = S_ACT;
      S_ACT:   if (cnt == '0) nxt = after_act;
      S_HOLD:  if (cnt == '0) nxt = after_hold;
      S_DONE:  if (clr_done) nxt = S_IDLE;
      default: nxt = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= S_IDLE;
      cnt   <= '0;
      left  <= '0;
      db_q  <= '0;
    end else begin
      state <= nxt;
      if (nxt != state)   cnt <= load_for(nxt);
      else if (cnt != '0) cnt <= cnt - PH_W'(1);
      if (state == S_IDLE && trig_req) left <= total;
      else if (take)                   left <= left - CNT_W'(1);
      if (take) db_q <= pix_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; mode <= 1'b0;
      cs_set <= '0; wr_set <= '0; wr_act <= PH_W'(1); wr_hold <= '0;
      hsize <= '0; vsize <= '0;
      done_flag <= 1'b0; te_late <= 1'b0; te_q <= 1'b0;
    end else begin
      te_q <= te;
      if (wr_time) begin
        cs_set  <= reg_wdata[19:16];
        wr_set  <= reg_wdata[15:12];
        wr_act  <= reg_wdata[11:8];
        wr_hold <= reg_wdata[7:4];
        en      <= reg_wdata[0];
      end
      if (wr_trig) mode <= reg_wdata[0];
      if (wr_size) begin
        hsize <= reg_wdata[DIM_W-1:0];
        vsize <= reg_wdata[16+DIM_W-1:16];
      end
      if (state != S_DONE && nxt == S_DONE) done_flag <= 1'b1;
      else if (clr_done)                    done_flag <= 1'b0;
      if (te_rise && in_xfer) te_late <= 1'b1;
      else if (clr_late)      te_late <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_TIME: reg_rdata = {12'd0, cs_set, wr_set, wr_act, wr_hold, 3'd0, en};
      A_TRIG: reg_rdata[0] = mode;
      A_STAT: reg_rdata[1:0] = {te_late, done_flag};
      default: begin
        reg_rdata[DIM_W-1:0]     = hsize;
        reg_rdata[16+DIM_W-1:16] = vsize;
      end
    endcase
  end

  assign cs_n      = !(state inside {S_CSS, S_WRS, S_ACT, S_HOLD});
  assign wr_n      = state != S_ACT;
  assign rs        = in_xfer;
  assign db        = db_q;
  assign pix_ready = state == S_FETCH;
  assign busy      = state != S_IDLE;
  assign irq       = done_flag;
endmodule

// File: rtl/i80_frame_writer_chk.sv
module i80_frame_writer_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [1:0]        reg_addr,
  input logic [31:0]       reg_wdata,
  input logic              pix_ready,
  input logic              cs_n,
  input logic              wr_n,
  input logic              rs,
  input logic [DATA_W-1:0] db,
  input logic              busy,
  input logic              irq
);
  // R1
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> (cs_n && wr_n));
  // R4
  strobe_in_select_chk: assert property (@(posedge clk) disable iff (!rst_n) !wr_n |-> !cs_n);
  // R4
  data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n) (!wr_n && !$past(wr_n)) |-> $stable(db));
  // R6
  ready_when_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) pix_ready |-> busy);
  // R7
  irq_with_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(irq) |-> busy);
  // R7
  irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !(reg_wr && reg_addr == 2'd2 && reg_wdata[0])) |=> irq);
  // R8
  retrigger_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 2'd1) |=> busy);
  // R10
  rs_with_select_chk: assert property (@(posedge clk) disable iff (!rst_n) !cs_n |-> rs);
endmodule

bind i80_frame_writer i80_frame_writer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
  .pix_ready(pix_ready), .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .db(db), .busy(busy), .irq(irq)
);

// File: tb/test_i80_frame_writer.sv
module test_i80_frame_writer;
  localparam int DW = 16;
  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic reg_wr = 0, pix_valid = 0, te = 0;
  logic [1:0] reg_addr = 0;
  logic [31:0] reg_wdata = 0, reg_rdata;
  logic [DW-1:0] pix_data = 0, db;
  logic pix_ready, cs_n, wr_n, rs, busy, irq;

  i80_frame_writer #(.DATA_W(DW), .DIM_W(11)) i_i80_frame_writer (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .pix_valid(pix_valid), .pix_ready(pix_ready), .pix_data(pix_data),
    .te(te), .cs_n(cs_n), .wr_n(wr_n), .rs(rs), .db(db), .busy(busy), .irq(irq));

  int checks = 0, errors = 0;
  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // bus monitor
  int rec_pre[64], rec_low[64], rec_post[64];
  logic [DW-1:0] rec_dat[64];
  int rec_n = 0, cur_pre = 0, cur_low = 0, cur_post = 0, rs_bad = 0, dat_bad = 0;
  bit seen_wr = 0, te_at_end = 0;
  logic prev_cs = 1;
  logic [DW-1:0] cur_dat;
  int tot_words = 0, exp_low = 1;

  always @(negedge clk) begin
    if (!cs_n) begin
      if (!rs) rs_bad++;
      if (!wr_n) begin
        if (seen_wr && db !== cur_dat) dat_bad++;
        cur_dat = db; seen_wr = 1; cur_low++;
      end else if (seen_wr) cur_post++;
      else cur_pre++;
    end else if (!prev_cs) begin
      if (rec_n < 64) begin
        rec_pre[rec_n] = cur_pre; rec_low[rec_n] = cur_low;
        rec_post[rec_n] = cur_post; rec_dat[rec_n] = cur_dat;
      end
      rec_n++;
      cur_pre = 0; cur_low = 0; cur_post = 0; seen_wr = 0;
    end
    prev_cs = cs_n;
    if (te_at_end && !wr_n && rec_n == tot_words - 1 && cur_low == exp_low) te = 1;
  end

  // pixel source
  int idx = 0;
  bit hs = 0, drv_on = 0, rnd_mode = 0;
  logic [DW-1:0] base = 0;
  function automatic logic [DW-1:0] pix_f(int k, logic [DW-1:0] b);
    return DW'(k * 40503 + int'(b) * 7 + 3);
  endfunction
  always @(negedge clk) begin
    if (hs) idx++;
    if (drv_on) begin
      pix_valid = rnd_mode ? ($urandom % 3 != 0) : 1'b1;
      pix_data  = pix_f(idx, base);
    end else pix_valid = 0;
    hs = pix_valid && pix_ready;
  end

  task automatic reg_write(logic [1:0] a, logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = 0;
  endtask
  task automatic reg_read(logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask
  function automatic logic [31:0] tword(int c, int w, int a, int h, bit e);
    return {12'd0, 4'(c), 4'(w), 4'(a), 4'(h), 3'd0, e};
  endfunction
  task automatic mon_clear();
    rec_n = 0; cur_pre = 0; cur_low = 0; cur_post = 0; seen_wr = 0; rs_bad = 0; dat_bad = 0;
  endtask

  task automatic run_frame(int c, int ws, int a, int h, int w, int l, bit rnd, bit te_end, bit retrig);
    int bad_pre = 0, bad_low = 0, bad_post = 0, bad_dat = 0, n;
    reg_write(0, tword(c, ws, a, h, 1));
    reg_write(3, (l << 16) | w);
    mon_clear();
    idx = 0; hs = 0; base = DW'($urandom); rnd_mode = rnd;
    tot_words = w * l; exp_low = (a == 0) ? 1 : a; te_at_end = te_end;
    drv_on = 1;
    reg_write(1, 3);
    if (retrig) begin
      repeat (5) @(negedge clk);
      reg_write(1, 3); // R8 mid-frame
    end
    n = 0;
    while (!irq && n < 20000) begin @(negedge clk); n++; end
    chk(irq, "R7", "irq after frame", irq, 1);
    repeat (3) @(negedge clk);
    te_at_end = 0; te = 0;
    if (retrig) begin
      reg_write(1, 3); // R8 in done state
      repeat (20) @(negedge clk);
    end
    chk(busy, "R7", "busy held until clear", busy, 1);
    chk(rec_n == tot_words, "R6", "word count", rec_n, tot_words);
    for (int k = 0; k < rec_n && k < 64; k++) begin
      if (rec_pre[k] != c + ws) bad_pre++;
      if (rec_low[k] != exp_low) bad_low++;
      if (rec_post[k] != h) bad_post++;
      if (rec_dat[k] !== pix_f(k, base)) bad_dat++;
    end
    chk(bad_pre == 0, "R3", "words with wrong setup time", bad_pre, 0);
    chk(bad_low == 0 && dat_bad == 0, "R4", "strobe width / data stability errors", bad_low + dat_bad, 0);
    chk(bad_post == 0, "R5", "words with wrong hold time", bad_post, 0);
    chk(bad_dat == 0, "R6", "words out of order", bad_dat, 0);
    chk(rs_bad == 0, "R10", "rs low with select", rs_bad, 0);
    drv_on = 0;
    reg_write(2, 1);
    chk(!busy && !irq, "R7", "busy/irq after clear", {busy, irq}, 0);
  endtask

  logic [31:0] rd;

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(cs_n && wr_n, "R1", "bus idle after reset", {cs_n, wr_n}, 3);
    chk(!busy && !irq && !pix_ready, "R1", "busy/irq/ready after reset", {busy, irq, pix_ready}, 0);
    reg_read(0, rd);
    chk(rd == 32'h100, "R1", "timing reset value", rd, 32'h100);

    // R2: enable clear
    mon_clear();
    reg_write(0, tword(0, 0, 1, 0, 0));
    reg_write(3, (1 << 16) | 2);
    reg_write(1, 3);
    repeat (10) @(negedge clk);
    chk(!busy && rec_n == 0, "R2", "trigger with interface off", busy, 0);
    // R2: mode bit clear
    reg_write(0, tword(0, 0, 1, 0, 1));
    reg_write(1, 2);
    repeat (10) @(negedge clk);
    chk(!busy && rec_n == 0, "R2", "trigger with mode off", busy, 0);

    // R9: te while idle
    @(negedge clk); te = 1; @(negedge clk); te = 0;
    reg_read(2, rd);
    chk(rd[1] == 0, "R9", "late flag after idle te", rd[1], 0);

    // directed frames
    run_frame(0, 0, 1, 0, 2, 2, 0, 0, 0);   // default timing
    run_frame(0, 0, 0, 0, 3, 1, 0, 0, 0);   // R4 zero active
    run_frame(15, 15, 15, 15, 2, 1, 0, 0, 0);
    run_frame(2, 1, 3, 2, 4, 3, 1, 0, 1);   // R8 retrigger

    // R7 zero-size frame, then R9 te in done state
    mon_clear();
    reg_write(3, 0);
    reg_write(1, 3);
    @(negedge clk);
    chk(irq && busy && rec_n == 0, "R7", "zero-size frame done", {irq, busy}, 3);
    te = 1; @(negedge clk); te = 0; @(negedge clk);
    reg_read(2, rd);
    chk(rd[1:0] == 2'b01, "R9", "te in done state", rd[1:0], 1);
    reg_write(2, 1);

    // R9 te on the edge where the last strobe completes
    run_frame(1, 0, 2, 0, 3, 2, 1, 1, 0);
    reg_read(2, rd);
    chk(rd[1:0] == 2'b10, "R9", "late flag after end-aligned te", rd[1:0], 2);
    reg_write(2, 2);
    reg_read(2, rd);
    chk(rd[1:0] == 2'b00, "R9", "late flag cleared", rd[1:0], 0);

    // constrained random frames
    for (int i = 0; i < 8; i++)
      run_frame($urandom % 16, $urandom % 16, $urandom % 16, $urandom % 16,
                1 + $urandom % 5, 1 + $urandom % 4, 1, 0, (i % 3) == 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule